// File: doc/BRIEF.md
# PLL Control and Lock-Interrupt Register Block

This block holds the software-visible controls and status of a clock generator's phase-locked loop. A CPU reaches three registers over a simple bus: address, write enable, write data, read enable and combinational read data. The block drives four outputs: the PLL run enable, the VCO frequency range field, the select line that steers an external clock multiplexer, and a CPU interrupt request. It takes a lock-detect level from the analog loop and brings it into the bus clock domain through a synchronizer.

Two guards protect the configuration. The range field cannot be changed while the loop is running. The clock source cannot be moved to the VCO while the range field is zero. Apart from that, source selection is left to software, and no lock check is made in hardware. When automatic mode is on, every change of lock state in either direction raises a sticky flag. A read of the control register clears the flag. The flag raises an interrupt only when the enable is also set.

Register map. Address 0 is the control register: bit 7 is the interrupt enable, bit 6 is the lock-change flag (read-only), bit 5 is the PLL run enable and bit 4 is the source select. Address 1 is the mode register: bit 7 is the automatic-mode bit and bit 6 is the synchronized lock status (read-only). Address 2 holds the range field in bits [RANGE_W-1:0]. Address 3 reads as zero. Bits not named here read as 0.

Top module: `pll_ctl_regs`

## Requirements
- R1: A write to address 2 updates `vco_range` on the next edge only when the PLL run enable is 0. While the run enable is 1, the write is ignored.
- R2: A control write with bit 4 = 1 leaves the source select unchanged when the range field is all zeros. A control write with bit 4 = 0 always clears the source select.
- R3: When the automatic-mode bit is 1, the lock-change flag (address 0, bit 6) sets on every change of the synchronized lock status, for both a rising and a falling change. The flag is readable from the third rising edge after `lock_in` changes.
- R4: The lock-change flag sets whether or not the interrupt enable (address 0, bit 7) is 1.
- R5: `irq_req` is 1 exactly when the lock-change flag, the interrupt enable and the automatic-mode bit are all 1.
- R6: While the automatic-mode bit is 0, the lock-change flag reads 0, `irq_req` is 0, and lock changes do not set the flag.
- R7: Source select can be set to 1 while the lock status is 0. It is gated by nothing but R2.
- R8: Address 1, bit 6 shows `lock_in` after the two-stage synchronizer, that is from the second rising edge after `lock_in` changes.
- R9: A read (rd_en = 1) of address 0 clears the lock-change flag. If a lock change sets the flag on that same edge, the flag stays set.
- R10: After reset, every control bit is 0, every register reads 0 and all outputs are 0.
- R11: Writes to the lock-change flag bit and the lock status bit neither set nor clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 0 clears the flag) |
| addr | input | 2 | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| lock_in | input | 1 | Lock-detect level from the analog loop (asynchronous) |
| pll_en | output | 1 | PLL run enable |
| vco_range | output | RANGE_W | VCO range select |
| src_sel | output | 1 | 1 selects the VCO clock divided by two as the base clock |
| irq_req | output | 1 | CPU interrupt request |

## Verification
The hardest case to reach is a clearing read of the control register that lands on the same edge as a new lock change. The bench toggles `lock_in` at a falling edge and counts through the synchronizer and the edge-detect register. It then holds the read strobe across exactly the third rising edge, so that the clear and the set meet on that edge. The range guard is swept over every pair of old and new range values in both run states. The interrupt gate is swept over every combination of enable and automatic mode, for both directions of lock change.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL  = 2'd0,
      REG_MODE  = 2'd1,
      REG_RANGE = 2'd2,
      REG_RSVD  = 2'd3
   } reg_sel_e;

   // control register field positions
   localparam int CTRL_IEN  = 7;
   localparam int CTRL_FLAG = 6;
   localparam int CTRL_RUN  = 5;
   localparam int CTRL_SRC  = 4;
   // mode register field positions
   localparam int MODE_AUTO = 7;
   localparam int MODE_LOCK = 6;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] stage_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[0] <= 1'b0;
            else        stage_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[i] <= 1'b0;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pll_lock_flag.sv
module pll_lock_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_s,
   input  logic auto_on,
   input  logic rd_clr,
   output logic lock_chg,
   output logic flag_vis
);
   logic lock_d;
   logic flag_q;

   assign lock_chg = lock_s ^ lock_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_d <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         lock_d <= lock_s;
         if (!auto_on)      flag_q <= 1'b0;
         else if (lock_chg) flag_q <= 1'b1;
         else if (rd_clr)   flag_q <= 1'b0;
      end
   end

   assign flag_vis = flag_q & auto_on;
endmodule

// File: rtl/pll_ctl_regfile.sv
module pll_ctl_regfile
   import pll_ctl_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int RANGE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               lock_s,
   input  logic               flag,
   output logic               ien_q,
   output logic               run_q,
   output logic               src_q,
   output logic               auto_q,
   output logic [RANGE_W-1:0] range_q,
   output logic [DATA_W-1:0]  rd_data
);
   logic range_zero;
   assign range_zero = (range_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q   <= 1'b0;
         run_q   <= 1'b0;
         src_q   <= 1'b0;
         auto_q  <= 1'b0;
         range_q <= '0;
      end else if (wr_en) begin
         case (reg_sel_e'(addr))
            REG_CTRL: begin
               ien_q <= wr_data[CTRL_IEN];
               run_q <= wr_data[CTRL_RUN];
               if (!(wr_data[CTRL_SRC] && range_zero)) src_q <= wr_data[CTRL_SRC];
            end
            REG_MODE:  auto_q <= wr_data[MODE_AUTO];
            REG_RANGE: if (!run_q) range_q <= wr_data[RANGE_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (reg_sel_e'(addr))
         REG_CTRL: begin
            rd_data[CTRL_IEN]  = ien_q;
            rd_data[CTRL_FLAG] = flag;
            rd_data[CTRL_RUN]  = run_q;
            rd_data[CTRL_SRC]  = src_q;
         end
         REG_MODE: begin
            rd_data[MODE_AUTO] = auto_q;
            rd_data[MODE_LOCK] = lock_s;
         end
         REG_RANGE: rd_data[RANGE_W-1:0] = range_q;
         default: ;
      endcase
   end
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
   import pll_ctl_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int RANGE_W     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               lock_in,
   output logic               pll_en,
   output logic [RANGE_W-1:0] vco_range,
   output logic               src_sel,
   output logic               irq_req
);
   if (DATA_W < 8) begin : g_bad_data_w
      $error("pll_ctl_regs: DATA_W must be at least 8");
   end
   if (RANGE_W < 1 || RANGE_W > DATA_W) begin : g_bad_range_w
      $error("pll_ctl_regs: RANGE_W must lie in 1..DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pll_ctl_regs: SYNC_STAGES must be at least 2");
   end

   logic lock_s, lock_chg, flag, ien_q, auto_q, rd_clr;

   assign rd_clr = rd_en && (reg_sel_e'(addr) == REG_CTRL);

   pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(lock_in), .sync_out(lock_s)
   );

   pll_lock_flag u_flag (
      .clk(clk), .rst_n(rst_n), .lock_s(lock_s), .auto_on(auto_q),
      .rd_clr(rd_clr), .lock_chg(lock_chg), .flag_vis(flag)
   );

   pll_ctl_regfile #(.DATA_W(DATA_W), .RANGE_W(RANGE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .lock_s(lock_s), .flag(flag), .ien_q(ien_q), .run_q(pll_en),
      .src_q(src_sel), .auto_q(auto_q), .range_q(vco_range), .rd_data(rd_data)
   );

   assign irq_req = flag & ien_q & auto_q;
endmodule

// File: rtl/pll_ctl_regs_chk.sv
module pll_ctl_regs_chk #(
   parameter int DATA_W  = 8,
   parameter int RANGE_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               rd_en,
   input logic [1:0]         addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic [DATA_W-1:0]  rd_data,
   input logic               pll_en,
   input logic [RANGE_W-1:0] vco_range,
   input logic               src_sel,
   input logic               irq_req,
   input logic               auto_bw,
   input logic               lock_chg,
   input logic               flag
);
   p_range_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd2 && pll_en) |=> $stable(vco_range));

   p_src_veto_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0 && wr_data[4] && vco_range == '0 && !src_sel) |=> !src_sel);

   p_flag_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_chg && auto_bw) |=> (flag || !auto_bw));

   p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (flag && auto_bw));

   p_auto_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_bw && addr == 2'd0) |-> !rd_data[6]);

   p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 2'd0 && !lock_chg) |=> !flag);
endmodule

bind pll_ctl_regs pll_ctl_regs_chk #(.DATA_W(DATA_W), .RANGE_W(RANGE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wr_data(wr_data), .rd_data(rd_data), .pll_en(pll_en), .vco_range(vco_range),
   .src_sel(src_sel), .irq_req(irq_req), .auto_bw(auto_q), .lock_chg(lock_chg),
   .flag(flag)
);

// File: tb/pll_ctl_regs_tb_top.sv
module pll_ctl_regs_tb_top;
   localparam int DW = 8;
   localparam int RW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, lock_in = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic pll_en, src_sel, irq_req;
   logic [RW-1:0] vco_range;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pll_ctl_regs #(.DATA_W(DW), .RANGE_W(RW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .lock_in(lock_in), .pll_en(pll_en),
      .vco_range(vco_range), .src_sel(src_sel), .irq_req(irq_req)
   );

   task automatic chk(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // clearing read: strobe held across one rising edge
   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1; #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b0; #1 d = rd_data;
   endtask

   task automatic toggle_lock();
      @(negedge clk);
      lock_in = ~lock_in;
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      chk("R10 pll_en", pll_en, 0);
      chk("R10 vco_range", vco_range, 0);
      chk("R10 src_sel", src_sel, 0);
      chk("R10 irq_req", irq_req, 0);
      for (int a = 0; a < 4; a++) begin
         peek(2'(a), d);
         chk("R10 readback", d, 0);
      end

      // R1 range guard: every old/new pair in both run states
      for (int p = 0; p < 4; p++)
         for (int n = 0; n < 4; n++)
            for (int on = 0; on < 2; on++) begin
               wr(2'd0, 8'h00);
               wr(2'd2, 8'(p));
               wr(2'd0, 8'(on << 5));
               wr(2'd2, 8'(n));
               chk("R1 vco_range", vco_range, on ? p : n);
               peek(2'd2, d);
               chk("R1 readback", d, on ? p : n);
            end
      wr(2'd0, 8'h00);

      // R2/R7 source veto against every range value, lock low
      for (int r = 0; r < 4; r++) begin
         wr(2'd0, 8'h00);
         wr(2'd2, 8'(r));
         wr(2'd0, 8'h10);
         chk("R2 R7 src_sel", src_sel, (r != 0) ? 1 : 0);
      end
      wr(2'd0, 8'h00);
      wr(2'd2, 8'd2);
      wr(2'd0, 8'h10);
      wr(2'd2, 8'd0);
      wr(2'd0, 8'h10);
      chk("R2 write of 1 with zero range keeps 1", src_sel, 1);
      wr(2'd0, 8'h00);
      chk("R2 write of 0 clears", src_sel, 0);

      // R3 R4 R5 R6 R8: enable x auto x both lock directions
      for (int ien = 0; ien < 2; ien++)
         for (int au = 0; au < 2; au++)
            for (int dir = 0; dir < 2; dir++) begin
               wr(2'd1, 8'(au << 7));
               wr(2'd0, 8'(ien << 7));
               rd(2'd0, d);
               toggle_lock();
               peek(2'd1, d);
               chk("R8 lock status", d[6], lock_in);
               peek(2'd0, d);
               chk("R3 R4 R6 flag", d[6], au);
               chk("R5 irq_req", irq_req, au & ien);
               rd(2'd0, d);
               peek(2'd0, d);
               chk("R9 flag cleared by read", d[6], 0);
               chk("R5 irq after clear", irq_req, 0);
            end

      // R9 clear and set on the same edge
      wr(2'd1, 8'h80);
      wr(2'd0, 8'h80);
      rd(2'd0, d);
      @(negedge clk);
      lock_in = ~lock_in;
      @(negedge clk);
      @(negedge clk);
      addr = 2'd0; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      peek(2'd0, d);
      chk("R9 collision keeps flag", d[6], 1);
      chk("R9 collision irq", irq_req, 1);

      // R11 writing 0 to the flag does not clear it
      wr(2'd0, 8'h80);
      peek(2'd0, d);
      chk("R11 flag not cleared by write", d[6], 1);

      // R6 turning auto off hides the flag
      wr(2'd1, 8'h00);
      peek(2'd0, d);
      chk("R6 flag hidden", d[6], 0);
      chk("R6 irq off", irq_req, 0);

      // R11 status bits cannot be set by writes
      wr(2'd1, 8'h80);
      rd(2'd0, d);
      wr(2'd0, 8'hC0);
      peek(2'd0, d);
      chk("R11 flag not set by write", d[6], 0);
      wr(2'd1, 8'h80 | 8'(!lock_in) << 6);
      peek(2'd1, d);
      chk("R11 lock not written", d[6], lock_in);

      finish_run();
   end
endmodule